// File: doc/BRIEF.md
# BCD Real-Time Calendar with Minute Alarm

This block keeps wall-clock time and the calendar date in packed BCD: seconds, minutes, 24-hour hours, a 0-to-6 weekday, day of month, month and a two-digit year covering 2000 to 2099. A free-running sub-second tick input feeds a prescaler; every `TICKS_PER_SEC` counted ticks advance the seconds, and carries ripple through the other fields with month lengths and leap years handled in hardware. A stop bit freezes counting so software can set the time without racing a carry.

A byte-wide register port reaches the time, a minute-resolution alarm (minute, hour, date), a sticky status register and a control register with the interrupt enables. Status flags for alarm, periodic timer and per-second update drive an active-low interrupt. Power-on and low-voltage flags mark the time as untrusted until software writes any time field. A snapshot strobe copies all seven time fields at once, so a multi-byte read of the time cannot see a half-carried value.

Top module: `rtc_bcd_core`

## Requirements
- R1: After reset the time reads 00:00:00, weekday 0, date 01, month 01, year 00; status reads 0x02 (power-on flag only); control reads 0x00; `irq_no` is high.
- R2: Seconds advance by one after `TICKS_PER_SEC` cycles with `tick_i` high; while control bit 0 (stop) is set, no time field changes.
- R3: Seconds 59 and minutes 59 wrap to 00 with a carry; hours wrap 23 to 00, advancing the date and the weekday, which counts 0 to 6 and wraps to 0.
- R4: April, June, September and November have 30 days, February 28, or 29 when the year value is divisible by four (year 00 included), the rest 31; month 12 wraps to 01 and increments the year, which wraps 99 to 00.
- R5: Time fields sit at addresses 0x01 seconds, 0x02 minutes, 0x03 hours, 0x04 weekday, 0x05 date, 0x06 month, 0x07 year; writes keep only the low 7 bits (seconds, minutes), 6 bits (hours, date), 5 bits (month), 3 bits (weekday) or all 8 bits (year).
- R6: A write to seconds restarts the prescaler, so the next second needs a full `TICKS_PER_SEC` ticks; a tick in a cycle that writes any time field is dropped.
- R7: Alarm minute, hour and date sit at 0x08, 0x09, 0x0A; status bit 3 sets when the seconds wrap to 00 and the new minute, hour and date all equal the alarm; seconds are never compared.
- R8: Status bit 5 sets on every seconds increment; status bit 4 sets on a `tmr_evt_i` pulse.
- R9: Writing status (0x0D) clears each flag written 0 and leaves each flag written 1; an event in the same cycle as its clear leaves the flag set; bits 2, 6, 7 read 0.
- R10: `low_volt_i` high sets status bit 0; a write to any time address clears status bits 0 and 1.
- R11: `irq_no` is low exactly when some status bit among 3, 4, 5 is set together with the control bit of the same index (0x11: bit 3 alarm, bit 4 timer, bit 5 update).
- R12: A `snap_i` pulse copies all time fields; reads of 0x01 to 0x07 return that copy until the next pulse; other registers read live and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Sub-second tick enable |
| tmr_evt_i | input | 1 | Periodic timer event pulse |
| low_volt_i | input | 1 | Supply low indication |
| snap_i | input | 1 | Capture time fields for reading |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| irq_no | output | 1 | Interrupt, active low |

## Verification
The bench drives the year-end, leap-February, non-leap February and 30-day month boundaries directly and then sweeps random dates biased toward last-day and 23:59:59, so a wrong month table or leap test shows up as a date of 29 or 31 where 01 is due. Prescaler restart and dropped-tick cases catch a design that carries a partial second across a seconds write, which would step the seconds a few ticks early. Alarm cases include a match at mid-minute, which a design comparing on every second would flag wrongly, and a clear racing a timer event, which a clear-wins design would lose. Stale snapshot reads catch a read path that bypasses the captured copy.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam logic [7:0] A_SEC   = 8'h01;
  localparam logic [7:0] A_MIN   = 8'h02;
  localparam logic [7:0] A_HOUR  = 8'h03;
  localparam logic [7:0] A_WDAY  = 8'h04;
  localparam logic [7:0] A_DATE  = 8'h05;
  localparam logic [7:0] A_MON   = 8'h06;
  localparam logic [7:0] A_YEAR  = 8'h07;
  localparam logic [7:0] A_AMIN  = 8'h08;
  localparam logic [7:0] A_AHOUR = 8'h09;
  localparam logic [7:0] A_ADATE = 8'h0A;
  localparam logic [7:0] A_STAT  = 8'h0D;
  localparam logic [7:0] A_CTRL  = 8'h11;

  localparam int ST_LV  = 0;
  localparam int ST_POR = 1;
  localparam int ST_AL  = 3;
  localparam int ST_TMR = 4;
  localparam int ST_UPD = 5;
  localparam logic [7:0] ST_MASK  = 8'b0011_1011;
  localparam logic [7:0] ST_RESET = 8'h02;
  localparam int CT_STOP = 0;
  localparam logic [7:0] CT_MASK  = 8'b0011_1001;

  typedef struct packed {
    logic [7:0] year;
    logic [4:0] mon;
    logic [5:0] date;
    logic [2:0] wday;
    logic [5:0] hour;
    logic [6:0] min;
    logic [6:0] sec;
  } cal_t;

  localparam cal_t CAL_RESET = '{year: 8'h00, mon: 5'h01, date: 6'h01,
                                 wday: 3'd0, hour: 6'h00, min: 7'h00, sec: 7'h00};

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // last day of month in BCD
  function automatic logic [5:0] month_len(input logic [4:0] mon, input logic [7:0] yr);
    logic [4:0] yq;
    logic [4:0] mb;
    yq = {3'b000, yr[4], 1'b0} + {1'b0, yr[3:0]};
    mb = mon[4] ? (5'd10 + {1'b0, mon[3:0]}) : {1'b0, mon[3:0]};
    case (mb)
      5'd2:                     return (yq[1:0] == 2'd0) ? 6'h29 : 6'h28;
      5'd4, 5'd6, 5'd9, 5'd11:  return 6'h30;
      default:                  return 6'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       stop_i,
  input  logic       time_wr_i,
  input  logic [7:0] addr_i,
  input  logic [7:0] wdata_i,
  output cal_t       cal_o,
  output logic       sec_evt_o,
  output logic       min_evt_o
);
  localparam int unsigned PW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [PW-1:0] P_LAST = PW'(TICKS_PER_SEC - 1);

  cal_t cal_q, cal_d;
  logic [PW-1:0] presc_q, presc_d;
  logic sec_w, min_w;

  always_comb begin
    cal_d   = cal_q;
    presc_d = presc_q;
    sec_w   = 1'b0;
    min_w   = 1'b0;
    if (time_wr_i) begin
      case (addr_i)
        A_SEC:  begin cal_d.sec = wdata_i[6:0]; presc_d = '0; end
        A_MIN:  cal_d.min  = wdata_i[6:0];
        A_HOUR: cal_d.hour = wdata_i[5:0];
        A_WDAY: cal_d.wday = wdata_i[2:0];
        A_DATE: cal_d.date = wdata_i[5:0];
        A_MON:  cal_d.mon  = wdata_i[4:0];
        A_YEAR: cal_d.year = wdata_i;
        default: ;
      endcase
    end else if (tick_i && !stop_i) begin
      if (presc_q != P_LAST) begin
        presc_d = presc_q + 1'b1;
      end else begin
        presc_d = '0;
        sec_w   = 1'b1;
        if (cal_q.sec < 7'h59) cal_d.sec = 7'(bcd_inc({1'b0, cal_q.sec}));
        else begin
          cal_d.sec = '0;
          min_w     = 1'b1;
          if (cal_q.min < 7'h59) cal_d.min = 7'(bcd_inc({1'b0, cal_q.min}));
          else begin
            cal_d.min = '0;
            if (cal_q.hour < 6'h23) cal_d.hour = 6'(bcd_inc({2'b00, cal_q.hour}));
            else begin
              cal_d.hour = '0;
              cal_d.wday = (cal_q.wday >= 3'd6) ? 3'd0 : cal_q.wday + 3'd1;
              if (cal_q.date < month_len(cal_q.mon, cal_q.year))
                cal_d.date = 6'(bcd_inc({2'b00, cal_q.date}));
              else begin
                cal_d.date = 6'h01;
                if (cal_q.mon < 5'h12) cal_d.mon = 5'(bcd_inc({3'b000, cal_q.mon}));
                else begin
                  cal_d.mon  = 5'h01;
                  cal_d.year = (cal_q.year >= 8'h99) ? 8'h00 : bcd_inc(cal_q.year);
                end
              end
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cal_q     <= CAL_RESET;
      presc_q   <= '0;
      sec_evt_o <= 1'b0;
      min_evt_o <= 1'b0;
    end else begin
      cal_q     <= cal_d;
      presc_q   <= presc_d;
      sec_evt_o <= sec_w;
      min_evt_o <= min_w;
    end
  end

  assign cal_o = cal_q;

  assert_sec_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !time_wr_i) |=> $stable(cal_q.sec));
  assert_stop_freeze_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !time_wr_i) |=> $stable(cal_q));
  assert_wday_carry_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !time_wr_i |=> ($stable(cal_q.wday) || $past(cal_q.hour) == 6'h23));
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
  import rtc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic       time_wr_i,
  input  logic [7:0] addr_i,
  input  logic [7:0] wdata_i,
  input  cal_t       cal_i,
  input  logic       sec_evt_i,
  input  logic       min_evt_i,
  input  logic       tmr_evt_i,
  input  logic       low_volt_i,
  output logic [6:0] al_min_o,
  output logic [5:0] al_hour_o,
  output logic [5:0] al_date_o,
  output logic [7:0] status_o,
  output logic [7:0] ctrl_o,
  output logic       irq_no
);
  logic [7:0] st_q, st_d, ctrl_q;
  logic [6:0] amin_q;
  logic [5:0] ahour_q, adate_q;
  logic alarm_hit, st_wr;

  assign st_wr = wr_i && (addr_i == A_STAT);
  // cal_i already holds the new minute when min_evt_i is high
  assign alarm_hit = min_evt_i && (cal_i.min == amin_q) &&
                     (cal_i.hour == ahour_q) && (cal_i.date == adate_q);

  always_comb begin
    st_d = st_q;
    if (st_wr)      st_d = st_q & (wdata_i | ~ST_MASK);
    if (time_wr_i) begin
      st_d[ST_LV]  = 1'b0;
      st_d[ST_POR] = 1'b0;
    end
    if (low_volt_i) st_d[ST_LV]  = 1'b1;
    if (sec_evt_i)  st_d[ST_UPD] = 1'b1;
    if (tmr_evt_i)  st_d[ST_TMR] = 1'b1;
    if (alarm_hit)  st_d[ST_AL]  = 1'b1;
    st_d = st_d & ST_MASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_RESET;
      ctrl_q  <= '0;
      amin_q  <= '0;
      ahour_q <= '0;
      adate_q <= '0;
    end else begin
      st_q <= st_d;
      if (wr_i) begin
        case (addr_i)
          A_CTRL:  ctrl_q  <= wdata_i & CT_MASK;
          A_AMIN:  amin_q  <= wdata_i[6:0];
          A_AHOUR: ahour_q <= wdata_i[5:0];
          A_ADATE: adate_q <= wdata_i[5:0];
          default: ;
        endcase
      end
    end
  end

  assign irq_no    = ~|(st_q[ST_UPD:ST_AL] & ctrl_q[ST_UPD:ST_AL]);
  assign status_o  = st_q;
  assign ctrl_o    = ctrl_q;
  assign al_min_o  = amin_q;
  assign al_hour_o = ahour_q;
  assign al_date_o = adate_q;

  assert_irq_source_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_no |-> (ctrl_q[ST_UPD:ST_AL] != 3'b000));
  assert_alarm_on_boundary_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(st_q[ST_AL]) |-> $past(min_evt_i));
  assert_write_one_keeps_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_wr && wdata_i[ST_UPD] && st_q[ST_UPD]) |=> st_q[ST_UPD]);
  assert_time_write_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (time_wr_i && !low_volt_i) |=> (st_q[ST_LV] == 1'b0 && st_q[ST_POR] == 1'b0));
endmodule

// File: rtl/rtc_rd_port.sv
module rtc_rd_port
  import rtc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       snap_i,
  input  cal_t       cal_i,
  input  logic [6:0] al_min_i,
  input  logic [5:0] al_hour_i,
  input  logic [5:0] al_date_i,
  input  logic [7:0] status_i,
  input  logic [7:0] ctrl_i,
  input  logic [7:0] addr_i,
  output logic [7:0] rdata_o
);
  cal_t snap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     snap_q <= CAL_RESET;
    else if (snap_i) snap_q <= cal_i;
  end

  always_comb begin
    case (addr_i)
      A_SEC:   rdata_o = {1'b0, snap_q.sec};
      A_MIN:   rdata_o = {1'b0, snap_q.min};
      A_HOUR:  rdata_o = {2'b00, snap_q.hour};
      A_WDAY:  rdata_o = {5'b0, snap_q.wday};
      A_DATE:  rdata_o = {2'b00, snap_q.date};
      A_MON:   rdata_o = {3'b000, snap_q.mon};
      A_YEAR:  rdata_o = snap_q.year;
      A_AMIN:  rdata_o = {1'b0, al_min_i};
      A_AHOUR: rdata_o = {2'b00, al_hour_i};
      A_ADATE: rdata_o = {2'b00, al_date_i};
      A_STAT:  rdata_o = status_i;
      A_CTRL:  rdata_o = ctrl_i;
      default: rdata_o = 8'h00;
    endcase
  end

  assert_snap_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snap_i |=> $stable(snap_q));
endmodule

// File: rtl/rtc_bcd_core.sv
module rtc_bcd_core
  import rtc_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       tmr_evt_i,
  input  logic       low_volt_i,
  input  logic       snap_i,
  input  logic       reg_wr_i,
  input  logic [7:0] reg_addr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  output logic       irq_no
);
  cal_t cal;
  logic sec_evt, min_evt, time_wr;
  logic [6:0] al_min;
  logic [5:0] al_hour, al_date;
  logic [7:0] status, ctrl;

  assign time_wr = reg_wr_i && (reg_addr_i >= A_SEC) && (reg_addr_i <= A_YEAR);

  rtc_calendar #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_cal (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .stop_i    (ctrl[CT_STOP]),
    .time_wr_i (time_wr),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .cal_o     (cal),
    .sec_evt_o (sec_evt),
    .min_evt_o (min_evt)
  );

  rtc_alarm_irq u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (reg_wr_i),
    .time_wr_i  (time_wr),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .cal_i      (cal),
    .sec_evt_i  (sec_evt),
    .min_evt_i  (min_evt),
    .tmr_evt_i  (tmr_evt_i),
    .low_volt_i (low_volt_i),
    .al_min_o   (al_min),
    .al_hour_o  (al_hour),
    .al_date_o  (al_date),
    .status_o   (status),
    .ctrl_o     (ctrl),
    .irq_no     (irq_no)
  );

  rtc_rd_port u_rd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .snap_i    (snap_i),
    .cal_i     (cal),
    .al_min_i  (al_min),
    .al_hour_i (al_hour),
    .al_date_i (al_date),
    .status_i  (status),
    .ctrl_i    (ctrl),
    .addr_i    (reg_addr_i),
    .rdata_o   (reg_rdata_o)
  );
endmodule

// File: tb/sim_rtc_bcd_core.sv
`timescale 1ns/1ps
module sim_rtc_bcd_core;
  localparam int TPS = 8;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, tmr = 1'b0, lv = 1'b0, snap = 1'b0, wr = 1'b0;
  logic [7:0] addr = 8'h00, wdata = 8'h00;
  logic [7:0] rdata;
  logic irq_n;
  int errs = 0, checks = 0;
  int ms, mm, mh, mw, md, mmo, my;

  always #5 clk = ~clk;

  rtc_bcd_core #(.TICKS_PER_SEC(TPS)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .tmr_evt_i(tmr), .low_volt_i(lv),
    .snap_i(snap), .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_no(irq_n)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] to_bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int dim(input int mo, input int y);
    case (mo)
      2: return (y % 4 == 0) ? 29 : 28;
      4, 6, 9, 11: return 30;
      default: return 31;
    endcase
  endfunction

  task automatic adv_model();
    ms++;
    if (ms == 60) begin
      ms = 0; mm++;
      if (mm == 60) begin
        mm = 0; mh++;
        if (mh == 24) begin
          mh = 0; mw = (mw + 1) % 7; md++;
          if (md > dim(mmo, my)) begin
            md = 1; mmo++;
            if (mmo == 13) begin mmo = 1; my = (my + 1) % 100; end
          end
        end
      end
    end
  endtask

  function automatic logic [55:0] exp_time();
    return {to_bcd(my), to_bcd(mmo), to_bcd(md), to_bcd(mw), to_bcd(mh), to_bcd(mm), to_bcd(ms)};
  endfunction

  task automatic wreg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rreg(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic take_snap();
    @(negedge clk); snap = 1'b1;
    @(negedge clk); snap = 1'b0;
  endtask

  task automatic do_ticks(input int n);
    @(negedge clk); tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_time(output logic [55:0] t);
    logic [7:0] b;
    take_snap();
    for (int i = 1; i <= 7; i++) begin
      rreg(8'(i), b);
      t[(i-1)*8 +: 8] = b;
    end
  endtask

  task automatic set_time(input int y, input int mo, input int d, input int wd,
                          input int h, input int m, input int s);
    my = y; mmo = mo; md = d; mw = wd; mh = h; mm = m; ms = s;
    wreg(8'h01, to_bcd(s)); wreg(8'h02, to_bcd(m)); wreg(8'h03, to_bcd(h));
    wreg(8'h04, to_bcd(wd)); wreg(8'h05, to_bcd(d)); wreg(8'h06, to_bcd(mo));
    wreg(8'h07, to_bcd(y));
  endtask

  task automatic one_second_check(input string req);
    logic [55:0] t;
    do_ticks(TPS);
    adv_model();
    idle(3);
    rd_time(t);
    chk(req, t, exp_time());
  endtask

  initial begin
    #1_500_000;
    errs++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks + 1);
    $finish;
  end

  initial begin
    logic [55:0] t;
    logic [7:0] b, b2;
    void'($urandom(32'd4242));
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    my = 0; mmo = 1; md = 1; mw = 0; mh = 0; mm = 0; ms = 0;
    rd_time(t);
    chk("R1 time", t, exp_time());
    rreg(8'h0D, b); chk("R1 status", b, 8'h02);
    rreg(8'h11, b); chk("R1 ctrl", b, 8'h00);
    chk("R1 irq", irq_n, 1'b1);

    // R5 field masks
    wreg(8'h03, 8'hFF); wreg(8'h04, 8'hFF); wreg(8'h06, 8'hFF); wreg(8'h01, 8'hFF);
    take_snap();
    rreg(8'h03, b); chk("R5 hour mask", b, 8'h3F);
    rreg(8'h04, b); chk("R5 wday mask", b, 8'h07);
    rreg(8'h06, b); chk("R5 month mask", b, 8'h1F);
    rreg(8'h01, b); chk("R5 sec mask", b, 8'h7F);
    rreg(8'h0B, b); chk("R12 unmapped", b, 8'h00);

    // R10 time write cleared power-on flag
    rreg(8'h0D, b); chk("R10 por cleared", b, 8'h00);
    @(negedge clk); lv = 1'b1; @(negedge clk); lv = 1'b0;
    rreg(8'h0D, b); chk("R10 low volt set", b, 8'h01);
    set_time(24, 5, 10, 3, 12, 0, 10);
    rreg(8'h0D, b); chk("R10 low volt cleared", b, 8'h00);

    // R6 prescaler restart on seconds write
    do_ticks(5);
    wreg(8'h01, 8'h20); ms = 20;
    do_ticks(TPS - 1); idle(2);
    take_snap(); rreg(8'h01, b); chk("R6 partial second", b, 8'h20);
    do_ticks(1); idle(2);
    take_snap(); rreg(8'h01, b); chk("R2 full second", b, 8'h21);

    // R6 tick during time write dropped
    @(negedge clk); addr = 8'h01; wdata = 8'h30; wr = 1'b1; tick = 1'b1;
    @(negedge clk); wr = 1'b0;
    repeat (TPS - 1) @(negedge clk);
    tick = 1'b0; idle(2);
    take_snap(); rreg(8'h01, b); chk("R6 dropped tick", b, 8'h30);
    do_ticks(1); idle(2);
    take_snap(); rreg(8'h01, b); chk("R6 after dropped", b, 8'h31);

    // R2 stop bit
    wreg(8'h11, 8'h01);
    do_ticks(3 * TPS); idle(2);
    take_snap(); rreg(8'h01, b); chk("R2 stop holds", b, 8'h31);
    wreg(8'h11, 8'h00);

    // R3 R4 directed boundaries
    set_time(99, 12, 31, 6, 23, 59, 59); one_second_check("R4 century wrap");
    set_time(24, 2, 28, 2, 23, 59, 59);  one_second_check("R4 leap feb 28");
    set_time(24, 2, 29, 3, 23, 59, 59);  one_second_check("R4 leap feb 29");
    set_time(23, 2, 28, 1, 23, 59, 59);  one_second_check("R4 non-leap feb");
    set_time(0, 2, 28, 1, 23, 59, 59);   one_second_check("R4 year 00 leap");
    set_time(21, 4, 30, 5, 23, 59, 59);  one_second_check("R4 30-day month");
    set_time(21, 7, 14, 6, 23, 59, 59);  one_second_check("R3 wday wrap");
    set_time(21, 7, 14, 2, 9, 59, 59);   one_second_check("R3 hour carry");

    // R3 R4 R8 random sweep
    for (int i = 0; i < 40; i++) begin
      int y, mo, d, h, m, s;
      y  = int'($urandom % 100);
      mo = 1 + int'($urandom % 12);
      d  = ($urandom % 2) ? dim(mo, y) : 1 + int'($urandom % dim(mo, y));
      h  = ($urandom % 2) ? 23 : int'($urandom % 24);
      m  = ($urandom % 2) ? 59 : int'($urandom % 60);
      s  = ($urandom % 2) ? 59 : int'($urandom % 60);
      wreg(8'h0D, 8'h00);
      set_time(y, mo, d, int'($urandom % 7), h, m, s);
      one_second_check("R3 R4 random");
      rreg(8'h0D, b); chk("R8 update flag", b & 8'h20, 8'h20);
    end

    // R9 write-1 keeps, write-0 clears
    rreg(8'h0D, b); chk("R8 update set", b, 8'h20);
    wreg(8'h0D, 8'hFF);
    rreg(8'h0D, b); chk("R9 write one keeps", b, 8'h20);
    wreg(8'h0D, 8'hDF);
    rreg(8'h0D, b); chk("R9 write zero clears", b, 8'h00);

    // R8 timer flag, R11 irq
    @(negedge clk); tmr = 1'b1; @(negedge clk); tmr = 1'b0;
    rreg(8'h0D, b); chk("R8 timer flag", b, 8'h10);
    chk("R11 irq disabled", irq_n, 1'b1);
    wreg(8'h11, 8'h10); #1;
    chk("R11 irq timer", irq_n, 1'b0);
    wreg(8'h11, 8'h20); #1;
    chk("R11 other enable", irq_n, 1'b1);
    wreg(8'h11, 8'h00);

    // R9 event in same cycle as clear wins
    @(negedge clk); addr = 8'h0D; wdata = 8'h00; wr = 1'b1; tmr = 1'b1;
    @(negedge clk); wr = 1'b0; tmr = 1'b0;
    rreg(8'h0D, b); chk("R9 set beats clear", b, 8'h10);
    wreg(8'h0D, 8'h00);

    // R7 alarm
    wreg(8'h08, 8'h15); wreg(8'h09, 8'h10); wreg(8'h0A, 8'h15);
    rreg(8'h08, b); chk("R7 alarm min reg", b, 8'h15);
    rreg(8'h0A, b); chk("R7 alarm date reg", b, 8'h15);
    set_time(30, 6, 15, 1, 10, 14, 59);
    do_ticks(TPS); idle(3);
    rreg(8'h0D, b); chk("R7 alarm hit", b & 8'h08, 8'h08);
    wreg(8'h11, 8'h08); #1;
    chk("R11 irq alarm", irq_n, 1'b0);
    wreg(8'h0D, 8'h00); #1;
    chk("R11 irq released", irq_n, 1'b1);
    set_time(30, 6, 15, 1, 10, 15, 30);
    do_ticks(TPS); idle(3);
    rreg(8'h0D, b); chk("R7 mid-minute no alarm", b & 8'h08, 8'h00);
    wreg(8'h09, 8'h11);
    set_time(30, 6, 15, 1, 10, 14, 59);
    do_ticks(TPS); idle(3);
    rreg(8'h0D, b); chk("R7 hour mismatch", b & 8'h08, 8'h00);
    chk("R11 no alarm irq", irq_n, 1'b1);
    wreg(8'h11, 8'h00);

    // R12 snapshot
    set_time(30, 6, 15, 1, 10, 20, 40);
    take_snap();
    rreg(8'h01, b);
    do_ticks(TPS); idle(3);
    rreg(8'h01, b2); chk("R12 stale until snap", b2, b);
    take_snap(); rreg(8'h01, b2); chk("R12 fresh after snap", b2, 8'h41);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule